// File: doc/BRIEF.md
# Dual-Mode Host Bus Slave Interface

This block sits between an asynchronous external host bus and a small internal register file. A static mode pin picks one of two bus styles. In the first style the host uses two separate active-low strobes, one for read and one for write. In the second style the host uses a read/write direction line and an active-low enable strobe. Every cycle needs the active-low chip select. The bidirectional 16-bit data bus is split into an input, an output and an output enable.

A multiplexed address/data bus is also supported. The host presents the address on the shared data lines and then drops the address-latch-enable input. The falling edge captures the address. When address-latch-enable is held high, the 11 dedicated address pins are used directly. Chip select, both strobes and address-latch-enable pass through two-flop synchronisers. A cycle begins when the synchronised strobe decode first shows an access, so each host cycle makes exactly one register access.

The register file holds eight scratch registers at addresses 0 to 7, a status register at 0x100 and a mask register at 0x101. Internal event pulses set status bits. Writing 1 to a status bit clears it. The interrupt output is high while any status bit is set together with its mask bit.

Top module: `hostBusIf`

## Requirements
- R1: After reset, dataOe and irqOut are 0, and every scratch, status and mask register reads back as 0.
- R2: With modeSel=0, strbA is the active-low write strobe and strbB is the active-low read strobe. A write is csN=0, strbA=0, strbB=1; it stores dataIn into the addressed register. A read is csN=0, strbB=0, strbA=1; it returns that register on dataOut.
- R3: With modeSel=1, strbA is the direction line (1 = read, 0 = write) and strbB is an active-low enable. A cycle starts when strbB goes low while csN=0.
- R4: While csN=1, strobe activity is ignored: no register changes, and dataOe stays 0.
- R5: dataOe is 1 only during a read cycle. It is never 1 during a write cycle, and it returns to 0 once the read strobe is released.
- R6: While dataOe is 1, dataOut holds a single value that does not change.
- R7: Each host cycle causes exactly one register access, taken at cycle start, however long the strobe is held. A status bit set by an event during a held write of 1 to that bit stays set.
- R8: When aleIn is low, the access uses the address captured from dataIn[10:0] on the falling edge of aleIn. When aleIn is high, the access uses addrIn.
- R9: Status bits (address 0x100) are set by statusEvt pulses and cleared by writing 1 to them. An event wins over a clear in the same cycle. Mask is read/write at 0x101.
- R10: irqOut is 1 exactly when some status bit and its mask bit are both 1.
- R11: Addresses outside 0..7, 0x100 and 0x101 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rstN | input | 1 | Active-low asynchronous reset |
| modeSel | input | 1 | Bus style: 0 separate strobes, 1 direction plus enable |
| csN | input | 1 | Active-low chip select |
| strbA | input | 1 | Write strobe (mode 0) or read/write line (mode 1) |
| strbB | input | 1 | Read strobe (mode 0) or enable strobe (mode 1) |
| aleIn | input | 1 | Address-latch-enable; held high for a non-multiplexed bus |
| addrIn | input | 11 | Dedicated address pins |
| dataIn | input | 16 | Data bus input side (also carries the address when multiplexed) |
| dataOut | output | 16 | Data bus output side |
| dataOe | output | 1 | Data bus output enable |
| statusEvt | input | 8 | Internal event pulses that set status bits |
| irqOut | output | 1 | Interrupt to the host |

## Verification
The bench holds a write strobe for many cycles while an event re-sets the status bit being cleared. A design that commits on every cycle of the strobe, instead of once at cycle start, would wipe that bit a second time. Multiplexed accesses put a decoy value on addrIn, so a design that ignores the latched address writes the wrong register. A cycle with chip select high, a write to an unmapped address and reads in both bus styles show up as a corrupted register or a stray output enable. The scoreboard also flags any output enable during a write and any change in read data while it is driven.

// File: rtl/hostBusPkg.sv
package hostBusPkg;
  localparam int AW = 11;
  localparam int DW = 16;

  typedef struct packed {
    logic          wrEn;
    logic          rdEn;
    logic [AW-1:0] addr;
  } busStrb_t;
endpackage

// File: rtl/hostBusSync.sv
module hostBusSync #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= RST_VAL;
      stage2 <= RST_VAL;
    end else begin
      stage1 <= din;
      stage2 <= stage1;
    end
  end

  assign dout = stage2;
endmodule

// File: rtl/hostBusCtrl.sv
module hostBusCtrl
  import hostBusPkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          modeSel,
  input  logic          csN,
  input  logic          strbA,
  input  logic          strbB,
  input  logic          aleIn,
  input  logic [AW-1:0] addrIn,
  input  logic [AW-1:0] muxBus,
  output busStrb_t      strb,
  output logic          dataOe
);
  localparam int NSYNC = 4;

  logic [NSYNC-1:0] syncOut;
  logic csS, aS, bS, aleS;
  logic rdAct, wrAct, anyAct, actPrev, cycStart;
  logic alePrev;
  logic [AW-1:0] latchedAddr;
  logic oeQ;

  hostBusSync #(.W(NSYNC), .RST_VAL('1)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({csN, strbA, strbB, aleIn}),
    .dout (syncOut)
  );

  assign {csS, aS, bS, aleS} = syncOut;

  always_comb begin
    rdAct = 1'b0;
    wrAct = 1'b0;
    if (!csS) begin
      if (!modeSel) begin
        rdAct = !bS && aS;
        wrAct = !aS && bS;
      end else begin
        rdAct = !bS && aS;
        wrAct = !bS && !aS;
      end
    end
  end

  assign anyAct   = rdAct || wrAct;
  assign cycStart = anyAct && !actPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actPrev     <= 1'b0;
      alePrev     <= 1'b1;
      latchedAddr <= '0;
      oeQ         <= 1'b0;
    end else begin
      actPrev <= anyAct;
      alePrev <= aleS;
      if (alePrev && !aleS) latchedAddr <= muxBus;
      if (cycStart && rdAct) oeQ <= 1'b1;
      else if (!rdAct)       oeQ <= 1'b0;
    end
  end

  assign strb.wrEn = cycStart && wrAct;
  assign strb.rdEn = cycStart && rdAct;
  assign strb.addr = aleS ? addrIn : latchedAddr;
  assign dataOe    = oeQ;

  AST_CS_GATES: assert property (@(posedge clk) disable iff (!rstN)
    csS |-> !strb.wrEn && !strb.rdEn); // R4
  AST_SINGLE_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn || strb.rdEn) |=> !(strb.wrEn || strb.rdEn)); // R7
  AST_OE_NOT_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (dataOe && !$past(wrAct)) |-> !strb.wrEn); // R5
  AST_OE_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (!rdAct) |=> !dataOe); // R5
endmodule

// File: rtl/hostBusRegs.sv
module hostBusRegs
  import hostBusPkg::*;
#(
  parameter int NREG  = 8,
  parameter int NSTAT = 8,
  parameter logic [AW-1:0] STAT_ADDR = 11'h100,
  parameter logic [AW-1:0] MASK_ADDR = 11'h101
) (
  input  logic             clk,
  input  logic             rstN,
  input  busStrb_t         strb,
  input  logic [DW-1:0]    wData,
  input  logic [NSTAT-1:0] statusEvt,
  output logic [DW-1:0]    rdData,
  output logic             irq
);
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

  logic [DW-1:0]    regQ [NREG];
  logic [NSTAT-1:0] statusQ, maskQ, clrBits;
  logic [DW-1:0]    rdNext, rdQ;
  logic             inScratch;

  assign inScratch = strb.addr < AW'(NREG);

  for (genvar g = 0; g < NREG; g++) begin : g_scratch
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) regQ[g] <= '0;
      else if (strb.wrEn && strb.addr == AW'(g)) regQ[g] <= wData;
    end
  end

  assign clrBits = (strb.wrEn && strb.addr == STAT_ADDR) ? wData[NSTAT-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      maskQ   <= '0;
    end else begin
      statusQ <= (statusQ & ~clrBits) | statusEvt;
      if (strb.wrEn && strb.addr == MASK_ADDR) maskQ <= wData[NSTAT-1:0];
    end
  end

  always_comb begin
    rdNext = '0;
    if (inScratch)                   rdNext = regQ[strb.addr[IDX_W-1:0]];
    else if (strb.addr == STAT_ADDR) rdNext = DW'(statusQ);
    else if (strb.addr == MASK_ADDR) rdNext = DW'(maskQ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdQ <= '0;
    else if (strb.rdEn) rdQ <= rdNext;
  end

  assign rdData = rdQ;
  assign irq    = |(statusQ & maskQ);

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && strb.addr == STAT_ADDR) |=>
      ((statusQ & $past(wData[NSTAT-1:0] & ~statusEvt)) == '0)); // R9
  AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (statusEvt != '0) |=> ((statusQ & $past(statusEvt)) == $past(statusEvt))); // R9
endmodule

// File: rtl/hostBusIf.sv
module hostBusIf
  import hostBusPkg::*;
#(
  parameter int NREG  = 8,
  parameter int NSTAT = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeSel,
  input  logic             csN,
  input  logic             strbA,
  input  logic             strbB,
  input  logic             aleIn,
  input  logic [AW-1:0]    addrIn,
  input  logic [DW-1:0]    dataIn,
  output logic [DW-1:0]    dataOut,
  output logic             dataOe,
  input  logic [NSTAT-1:0] statusEvt,
  output logic             irqOut
);
  busStrb_t strb;

  hostBusCtrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .modeSel (modeSel),
    .csN     (csN),
    .strbA   (strbA),
    .strbB   (strbB),
    .aleIn   (aleIn),
    .addrIn  (addrIn),
    .muxBus  (dataIn[AW-1:0]),
    .strb    (strb),
    .dataOe  (dataOe)
  );

  hostBusRegs #(.NREG(NREG), .NSTAT(NSTAT)) u_regs (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wData     (dataIn),
    .statusEvt (statusEvt),
    .rdData    (dataOut),
    .irq       (irqOut)
  );

  AST_RD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (dataOe && $past(dataOe)) |-> $stable(dataOut)); // R6
endmodule

// File: tb/hostBusIf_bench.sv
module hostBusIf_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modeSel = 1'b0;
  logic        csN = 1'b1;
  logic        strbA = 1'b1;
  logic        strbB = 1'b1;
  logic        aleIn = 1'b1;
  logic [10:0] addrIn = '0;
  logic [15:0] dataIn = '0;
  logic [15:0] dataOut;
  logic        dataOe;
  logic [7:0]  statusEvt = '0;
  logic        irqOut;

  int total = 0;
  int bad = 0;
  int oeCount = 0;
  int stableErrs = 0;
  logic        prevOe = 1'b0;
  logic [15:0] prevOut = '0;
  logic [15:0] expData[$];
  string       expTag[$];

  always #5 clk = ~clk;

  hostBusIf u_hostBusIf (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .csN(csN),
    .strbA(strbA), .strbB(strbB), .aleIn(aleIn), .addrIn(addrIn),
    .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .statusEvt(statusEvt), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard when the block starts driving the bus
  always @(negedge clk) begin
    if (dataOe) oeCount++;
    if (dataOe && prevOe && dataOut !== prevOut) stableErrs++;
    if (dataOe && !prevOe) begin
      if (expData.size() == 0) begin
        check("R5 unexpected drive", 16'h1, 16'h0);
      end else begin
        check(expTag.pop_front(), dataOut, expData.pop_front());
      end
    end
    prevOe  = dataOe;
    prevOut = dataOut;
  end

  task automatic hostCycle(input bit isRd, input bit md, input bit mux,
                           input logic [10:0] a, input logic [15:0] d,
                           input bit evtMid, input bit csHigh, input string req);
    int oeBefore;
    @(negedge clk);
    modeSel = md;
    if (mux) begin
      addrIn = 11'h002;
      aleIn  = 1'b1;
      dataIn = {5'd0, a};
      repeat (4) @(negedge clk);
      aleIn = 1'b0;
      repeat (5) @(negedge clk);
    end else begin
      addrIn = a;
    end
    dataIn = isRd ? 16'h0 : d;
    if (isRd && !csHigh) begin
      expData.push_back(d);
      expTag.push_back(req);
    end
    oeBefore = oeCount;
    csN = csHigh;
    if (!md) begin
      if (isRd) strbB = 1'b0; else strbA = 1'b0;
    end else begin
      strbA = isRd;
      @(negedge clk);
      strbB = 1'b0;
    end
    repeat (6) @(negedge clk);
    if (evtMid) begin
      statusEvt = 8'h01;
      @(negedge clk);
      statusEvt = 8'h00;
    end
    repeat (3) @(negedge clk);
    strbB = 1'b1;
    if (md) @(negedge clk);
    strbA = 1'b1;
    csN   = 1'b1;
    aleIn = 1'b1;
    repeat (5) @(negedge clk);
    if (!isRd) check({req, " R5 no drive in write"}, 16'(oeCount - oeBefore), 16'h0);
    if (isRd && csHigh) check("R4 no drive with csN high", 16'(oeCount - oeBefore), 16'h0);
  endtask

  task automatic runTests;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 dataOe reset", {15'd0, dataOe}, 16'h0);
    check("R1 irqOut reset", {15'd0, irqOut}, 16'h0);
    hostCycle(1, 0, 0, 11'h003, 16'h0000, 0, 0, "R1 scratch reset");
    hostCycle(1, 0, 0, 11'h100, 16'h0000, 0, 0, "R1 status reset");
    hostCycle(1, 0, 0, 11'h101, 16'h0000, 0, 0, "R1 mask reset");

    hostCycle(0, 0, 0, 11'h003, 16'hA5A5, 0, 0, "R2 write");
    hostCycle(1, 0, 0, 11'h003, 16'hA5A5, 0, 0, "R2 read reg3");
    hostCycle(0, 0, 0, 11'h000, 16'h1234, 0, 0, "R2 write");
    hostCycle(1, 0, 0, 11'h000, 16'h1234, 0, 0, "R2 read reg0");

    hostCycle(0, 1, 0, 11'h005, 16'hBEEF, 0, 0, "R3 write");
    hostCycle(1, 1, 0, 11'h005, 16'hBEEF, 0, 0, "R3 read reg5");
    hostCycle(1, 1, 0, 11'h003, 16'hA5A5, 0, 0, "R3 read reg3");

    hostCycle(0, 0, 0, 11'h003, 16'h0000, 0, 1, "R4 write ignored");
    hostCycle(0, 1, 0, 11'h005, 16'h0000, 0, 1, "R4 write ignored");
    hostCycle(1, 0, 0, 11'h003, 16'h0000, 0, 1, "R4 read ignored");
    hostCycle(1, 0, 0, 11'h003, 16'hA5A5, 0, 0, "R4 reg3 kept");
    hostCycle(1, 1, 0, 11'h005, 16'hBEEF, 0, 0, "R4 reg5 kept");

    hostCycle(0, 0, 1, 11'h007, 16'hCAFE, 0, 0, "R8 muxed write");
    hostCycle(1, 1, 1, 11'h007, 16'hCAFE, 0, 0, "R8 muxed read reg7");
    hostCycle(1, 0, 0, 11'h002, 16'h0000, 0, 0, "R8 decoy reg2 untouched");

    hostCycle(0, 0, 0, 11'h300, 16'hFFFF, 0, 0, "R11 unmapped write");
    hostCycle(1, 0, 0, 11'h300, 16'h0000, 0, 0, "R11 unmapped read");
    hostCycle(1, 0, 0, 11'h000, 16'h1234, 0, 0, "R11 reg0 untouched");

    @(negedge clk);
    statusEvt = 8'h05;
    @(negedge clk);
    statusEvt = 8'h00;
    repeat (2) @(negedge clk);
    check("R10 irq masked off", {15'd0, irqOut}, 16'h0);
    hostCycle(0, 0, 0, 11'h101, 16'h0004, 0, 0, "R9 mask write");
    check("R10 irq on", {15'd0, irqOut}, 16'h1);
    hostCycle(1, 1, 0, 11'h101, 16'h0004, 0, 0, "R9 mask read");
    hostCycle(1, 0, 0, 11'h100, 16'h0005, 0, 0, "R9 status read");
    hostCycle(0, 1, 0, 11'h100, 16'h0004, 0, 0, "R9 w1c");
    check("R10 irq off after clear", {15'd0, irqOut}, 16'h0);
    hostCycle(1, 0, 0, 11'h100, 16'h0001, 0, 0, "R9 status after w1c");

    hostCycle(0, 0, 0, 11'h100, 16'h0001, 1, 0, "R7 held write");
    hostCycle(1, 0, 0, 11'h100, 16'h0001, 0, 0, "R7 one commit only");
    hostCycle(0, 1, 0, 11'h100, 16'h0001, 1, 0, "R7 held write");
    hostCycle(1, 1, 0, 11'h100, 16'h0001, 0, 0, "R7 one commit only");

    repeat (4) @(negedge clk);
    check("R5 scoreboard drained", 16'(expData.size()), 16'h0);
    check("R6 read data stable", 16'(stableErrs), 16'h0);
  endtask

  initial begin
    fork
      runTests();
      begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule